// File: doc/BRIEF.md
# Rotating Lane Inversion Mask

This block sits beside a multi-lane link self-test pattern generator and decides, lane by lane, whether each lane sends the shared test pattern as it is or its bitwise complement. Lanes that send the complement act as aggressors against their neighbours, which creates crosstalk stress on the link. Software loads a 14-bit mask through a simple register write port, with one bit for each lane. A readback port returns the current mask.

While self-test runs, the mask rotates one place to the left each time the loop counter signals that a test loop has finished, so the aggressor lanes walk across the link. Pattern generation, loop counting and serialisation happen outside this block.

The mask has two separate reset levels. A cold reset restores the default mask, in which only lane 0 inverts. A warm reset keeps the programmed mask and clears only the registered lane outputs.

Top module: `lane_invert_mask`

## Requirements
- R1: After a cold reset the mask reads back as 0x00000001 (low field bits 9:0 = 10'h001, upper field bits 13:10 = 4'h0) and every lane output bit is 0.
- R2: A write with `wr_en` high loads `wr_data[13:0]` into the mask at the next clock edge. Bits 31:14 of `wr_data` are ignored, and bits 31:14 of `mask_rd` always read 0.
- R3: Lane i occupies `lane_data[i*PAT_W +: PAT_W]`. One clock edge after `pattern_in` is presented, lane i holds `pattern_in` inverted if mask bit i was 1 at that edge, and unchanged if it was 0.
- R4: When `test_active` and `loop_done` are both high and there is no write, the mask rotates left by one at the clock edge. Bit 13 wraps into bit 0.
- R5: When `test_active` or `loop_done` is low and there is no write, the mask keeps its value.
- R6: When a write and a rotation request arrive in the same cycle, the written value is loaded and no rotation is applied.
- R7: A warm reset leaves the mask unchanged and clears all lane output bits to 0 at the next edge.
- R8: After 14 rotations with no writes in between, the mask equals its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high cold reset; restores the default mask |
| warm_rst | input | 1 | Synchronous active-high warm reset; clears the lane outputs only |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; bits 13:0 hold the mask |
| test_active | input | 1 | Self-test is running |
| loop_done | input | 1 | One-cycle pulse at the end of each test loop |
| pattern_in | input | PAT_W | Shared test pattern |
| lane_data | output | 14*PAT_W | Registered per-lane pattern, inverted where the mask bit is 1 |
| mask_rd | output | 32 | Mask readback; bits 31:14 are 0 |

## Verification
The bench uses the default parameters: 14 lanes, a 10/4 field split and a two-bit pattern per lane. With two pattern bits per lane, a lane that inverts cannot be mistaken for one that is forced to a constant. With 14 lanes, the wrap from bit 13 into bit 0 and a full 14-step return to the starting value both fall within a short run. The stimulus table feeds write-only, rotate-only and combined cycles to the mask. On every step it compares the readback and all 28 lane bits against values the bench computes from the mask that held before the edge.

// File: rtl/lim_pkg.sv
package lim_pkg;
    localparam int MASK_W = 14;
    localparam int LO_W   = 10;
    localparam int HI_W   = MASK_W - LO_W;
    localparam int REG_W  = 32;
    localparam int PAT_W  = 2;

    localparam logic [LO_W-1:0] LO_DFLT = LO_W'(1);
    localparam logic [HI_W-1:0] HI_DFLT = '0;

    typedef logic [MASK_W-1:0] mask_t;

    typedef enum logic [1:0] {
        MSK_HOLD = 2'd0,
        MSK_LOAD = 2'd1,
        MSK_ROT  = 2'd2
    } mask_op_e;

    typedef struct packed {
        mask_op_e op;
        mask_t    wdata;
    } mask_cmd_t;

    function automatic mask_t rotl1(input mask_t m);
        return {m[MASK_W-2:0], m[MASK_W-1]};
    endfunction
endpackage

// File: rtl/lim_mask_ctl.sv
module lim_mask_ctl
    import lim_pkg::*;
(
    input  logic            wr_en,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic            test_active,
    input  logic            loop_done,
    output mask_cmd_t       cmd
);
    always_comb begin
        cmd.wdata = wr_mask;
        if (wr_en)
            cmd.op = MSK_LOAD;
        else if (test_active && loop_done)
            cmd.op = MSK_ROT;
        else
            cmd.op = MSK_HOLD;
    end
endmodule

// File: rtl/lim_mask_reg.sv
module lim_mask_reg
    import lim_pkg::*;
(
    input  logic      clk,
    input  logic      cold_rst,
    input  mask_cmd_t cmd,
    output mask_t     mask
);
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    mask_t           nxt;

    assign mask = {hi_q, lo_q};

    always_comb begin
        unique case (cmd.op)
            MSK_LOAD: nxt = cmd.wdata;
            MSK_ROT:  nxt = rotl1(mask);
            default:  nxt = mask;
        endcase
    end

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            lo_q <= LO_DFLT;
            hi_q <= HI_DFLT;
        end else begin
            lo_q <= nxt[LO_W-1:0];
            hi_q <= nxt[MASK_W-1:LO_W];
        end
    end

    // R4: a rotation request without a write walks the mask one place left
    a_r4_rotate: assert property (@(posedge clk) disable iff (cold_rst)
        (cmd.op == MSK_ROT) |=> mask == {$past(mask[MASK_W-2:0]), $past(mask[MASK_W-1])});

    // R5: with no write and no rotation the mask keeps its value
    a_r5_hold: assert property (@(posedge clk) disable iff (cold_rst)
        (cmd.op == MSK_HOLD) |=> $stable(mask));

    // R6: the written value is loaded even when a rotation is requested
    a_r6_write_wins: assert property (@(posedge clk) disable iff (cold_rst)
        (cmd.op == MSK_LOAD) |=> mask == $past(cmd.wdata));
endmodule

// File: rtl/lim_lane_xor.sv
module lim_lane_xor
    import lim_pkg::*;
#(
    parameter int LANES = MASK_W,
    parameter int PW    = PAT_W
) (
    input  logic               clk,
    input  logic               clr,
    input  logic [LANES-1:0]   mask,
    input  logic [PW-1:0]      pattern,
    output logic [LANES*PW-1:0] lanes
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PW-1:0] q;
        always_ff @(posedge clk) begin
            if (clr)
                q <= '0;
            else
                q <= pattern ^ {PW{mask[g]}};
        end
        assign lanes[g*PW +: PW] = q;
    end
endmodule

// File: rtl/lane_invert_mask.sv
module lane_invert_mask
    import lim_pkg::*;
(
    input  logic                    clk,
    input  logic                    cold_rst,
    input  logic                    warm_rst,
    input  logic                    wr_en,
    input  logic [REG_W-1:0]        wr_data,
    input  logic                    test_active,
    input  logic                    loop_done,
    input  logic [PAT_W-1:0]        pattern_in,
    output logic [MASK_W*PAT_W-1:0] lane_data,
    output logic [REG_W-1:0]        mask_rd
);
    mask_cmd_t cmd;
    mask_t     mask;
    logic      unused_wr_hi;

    assign unused_wr_hi = ^wr_data[REG_W-1:MASK_W];

    lim_mask_ctl u_ctl (
        .wr_en       (wr_en),
        .wr_mask     (wr_data[MASK_W-1:0]),
        .test_active (test_active),
        .loop_done   (loop_done),
        .cmd         (cmd)
    );

    lim_mask_reg u_reg (
        .clk      (clk),
        .cold_rst (cold_rst),
        .cmd      (cmd),
        .mask     (mask)
    );

    lim_lane_xor #(.LANES(MASK_W), .PW(PAT_W)) u_xor (
        .clk     (clk),
        .clr     (cold_rst || warm_rst),
        .mask    (mask),
        .pattern (pattern_in),
        .lanes   (lane_data)
    );

    assign mask_rd = {{(REG_W-MASK_W){1'b0}}, mask};

    // R7: a warm reset clears the lane outputs at the next edge
    a_r7_warm_clear: assert property (@(posedge clk) disable iff (cold_rst)
        warm_rst |=> lane_data == '0);
endmodule

// File: tb/tb_lane_invert_mask.sv
module tb_lane_invert_mask;
    localparam int MW = 14;
    localparam int PW = 2;
    localparam int NV = 9;

    logic            clk = 0;
    logic            cold_rst = 1, warm_rst = 0, wr_en = 0;
    logic [31:0]     wr_data = '0;
    logic            test_active = 0, loop_done = 0;
    logic [PW-1:0]   pattern_in = '0;
    logic [MW*PW-1:0] lane_data;
    logic [31:0]     mask_rd;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lane_invert_mask dut (
        .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .wr_en(wr_en),
        .wr_data(wr_data), .test_active(test_active), .loop_done(loop_done),
        .pattern_in(pattern_in), .lane_data(lane_data), .mask_rd(mask_rd)
    );

    // {wr_en, test_active, loop_done, wr_data, expected mask}
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 32'h3FFF_C005, 14'h0005},  // R2 upper bits dropped
        {1'b0, 1'b1, 1'b1, 32'h0,         14'h000A},  // R4
        {1'b0, 1'b0, 1'b1, 32'h0,         14'h000A},  // R5 idle
        {1'b0, 1'b1, 1'b0, 32'h0,         14'h000A},  // R5 no pulse
        {1'b1, 1'b0, 1'b0, 32'h0000_2001, 14'h2001},  // R2
        {1'b0, 1'b1, 1'b1, 32'h0,         14'h0003},  // R4 wrap
        {1'b1, 1'b1, 1'b1, 32'h0000_1234, 14'h1234},  // R6
        {1'b0, 1'b1, 1'b1, 32'h0,         14'h2468},  // R4
        {1'b0, 1'b1, 1'b1, 32'h0,         14'h08D1}   // R4 wrap
    };

    function automatic logic [MW*PW-1:0] exp_lanes(input logic [MW-1:0] m,
                                                   input logic [PW-1:0] p);
        logic [MW*PW-1:0] r;
        for (int i = 0; i < MW; i++)
            r[i*PW +: PW] = m[i] ? ~p : p;
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [31:0] d, input logic a,
                         input logic l, input logic [PW-1:0] p);
        @(negedge clk);
        wr_en = w; wr_data = d; test_active = a; loop_done = l; pattern_in = p;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 0; test_active = 0; loop_done = 0;
    endtask

    initial begin
        logic [MW-1:0] prev;
        logic [MW-1:0] start;
        logic [PW-1:0] pat;
        repeat (3) @(posedge clk);
        #1;
        check("R1 mask default", 64'(mask_rd), 64'h1);
        check("R1 lanes cleared", 64'(lane_data), 64'h0);
        @(negedge clk);
        cold_rst = 0;

        prev = 14'h0001;
        for (int v = 0; v < NV; v++) begin
            pat = PW'(v + 1);
            drive(VEC[v][48], VEC[v][45:14], VEC[v][47], VEC[v][46], pat);
            check($sformatf("R2/R4/R5/R6 step %0d mask", v), 64'(mask_rd), 64'(VEC[v][13:0]));
            check($sformatf("R3 step %0d lanes", v), 64'(lane_data), 64'(exp_lanes(prev, pat)));
            prev = VEC[v][13:0];
        end

        // R2: bits 31:14 always read zero
        drive(1, 32'hFFFF_FFFF, 0, 0, 2'b00);
        check("R2 readback upper zero", 64'(mask_rd), 64'h3FFF);

        // R8: 14 rotations return to the start value
        start = 14'h0A53;
        drive(1, 32'(start), 0, 0, 2'b10);
        drive(0, 0, 1, 1, 2'b10);
        check("R8 first step moved", 64'(mask_rd), 64'h14A6);
        for (int k = 1; k < MW; k++) begin
            drive(0, 0, 1, 1, 2'b10);
            drive(0, 0, 1, 0, 2'b10);
        end
        check("R8 full circle", 64'(mask_rd), 64'(start));

        // R7: warm reset keeps the mask and clears the lanes
        drive(1, 32'h1111, 0, 0, 2'b11);
        drive(0, 0, 0, 0, 2'b11);
        check("R3 lanes before warm", 64'(lane_data), 64'(exp_lanes(14'h1111, 2'b11)));
        @(negedge clk); warm_rst = 1; pattern_in = 2'b01;
        @(posedge clk); #1;
        check("R7 mask kept", 64'(mask_rd), 64'h1111);
        check("R7 lanes cleared", 64'(lane_data), 64'h0);
        @(negedge clk); warm_rst = 0;
        @(posedge clk); #1;
        check("R7 lanes resume", 64'(lane_data), 64'(exp_lanes(14'h1111, 2'b01)));

        // R1: cold reset restores the defaults
        @(negedge clk); cold_rst = 1;
        @(posedge clk); #1;
        check("R1 cold restores mask", 64'(mask_rd), 64'h1);
        check("R1 cold clears lanes", 64'(lane_data), 64'h0);
        idle();
        cold_rst = 0;

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule